// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This engine reads and writes the 16-bit internal control registers of a serial-link PHY. The PHY exposes only a parallel control word and a status word. The engine turns one host command into the full strobe sequence. Every step is a four-phase handshake: the engine moves one strobe, then polls the PHY acknowledge until it follows. If the acknowledge never follows, the engine reports an error instead of hanging.

The host side is a valid/ready command port. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the engine is idle, so a host that holds `cmd_valid` is stalled until the previous access has finished. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse. `rsp_rdata` and `rsp_err` stay valid after the pulse and change only when the next command is taken or when that command finishes.

The PHY side carries one shared 16-bit field and four strobes: capture-address, capture-data, write and read. The poll interval, the number of polls before a timeout, the idle delay before each access, and the address of the PHY clock-reset register are all parameters.

Top module: `phyreg_hs_master`

## Requirements
- R1: After reset, all four strobes are low, `cmd_ready` is high, and `rsp_valid` and `rsp_err` are low.
- R2: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that point until the response pulse. A command offered in that time has no effect on the PHY.
- R3: Every access begins with an address phase. The command address is put on `phy_field`, then `phy_cap_addr` is raised and later lowered.
- R4: After each strobe change, the engine samples `phy_ack` once every POLL_CYCLES cycles. It takes its next step only after a sample in which `phy_ack` equals the new strobe level.
- R5: After the address phase, a write puts the write data on `phy_field`. It then performs a full `phy_cap_data` handshake, followed by a full `phy_wr` handshake, and completes with `rsp_err` low.
- R6: After the address phase, a read raises `phy_rd`. It captures `phy_dout` on the sample where `phy_ack` is high, then lowers `phy_rd` and waits for `phy_ack` low. The captured value is returned on `rsp_rdata`.
- R7: A write to the clock-reset address RST_ADDR with nonzero data raises `phy_wr` and completes without waiting for any acknowledge on it, with `rsp_err` low. `phy_wr` stays high until the next command is taken. With zero data, the same address uses the normal handshake.
- R8: If TIMEOUT_POLLS samples in a row fail to match, the engine drops every strobe and ends the access with `rsp_valid` and `rsp_err` high.
- R9: `rsp_valid` is high for exactly one cycle per command. `rsp_err` holds its value until the next command is taken, and is low on the cycle after that.
- R10: At most one strobe is high at a time. `phy_field` does not change while a strobe stays high.
- R11: The first `phy_cap_addr` rise comes IDLE_CYCLES+1 clock edges after the edge that takes the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle; the command is taken this cycle if valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | DW | PHY register address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Data returned by the last read |
| rsp_err | output | 1 | Last access timed out |
| phy_field | output | DW | Shared address/data field to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | DW | PHY read data |

## Verification
A sequencer that skips or repeats a step would show an out-of-order strobe rise on the PHY pins. That error appears on the same cycle as the rise, because each rise is matched against the expected step and field value. A wrong poll counter or a wrong acknowledge comparison changes the error flag, or the data returned at the response pulse of that access. A stale error flag shows one cycle after the next command is taken. A wrong idle counter shifts the first capture-address rise away from its exact expected cycle.

// File: rtl/phyreg_hs_pkg.sv
package phyreg_hs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_GAP,
    S_DRIVE,
    S_WAIT,
    S_FIN
  } seq_state_t;

  // Step code doubles as the strobe bit index.
  typedef enum logic [1:0] {
    ST_ADDR = 2'd0,
    ST_DATA = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } step_t;

  localparam int NUM_STROBES = 4;

endpackage

// File: rtl/phyreg_hs_pacer.sv
module phyreg_hs_pacer #(
  parameter int POLL_CYCLES   = 10000,
  parameter int TIMEOUT_POLLS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick,
  output logic last
);
  localparam int IW = $clog2(POLL_CYCLES + 1);
  localparam int PW = $clog2(TIMEOUT_POLLS + 1);

  logic [IW-1:0] icnt;
  logic [PW-1:0] pcnt;

  assign tick = en && (icnt == IW'(POLL_CYCLES - 1));
  assign last = tick && (pcnt == PW'(TIMEOUT_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      icnt <= '0;
      pcnt <= '0;
    end else if (en) begin
      if (tick) begin
        icnt <= '0;
        if (!last) pcnt <= pcnt + 1'b1;
      end else begin
        icnt <= icnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/phyreg_hs_seq.sv
module phyreg_hs_seq
  import phyreg_hs_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          IDLE_CYCLES = 10000,
  parameter logic [15:0] RST_ADDR    = 16'h7F3F
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_write,
  input  logic [DW-1:0]          cmd_addr,
  input  logic [DW-1:0]          cmd_wdata,
  output logic                   rsp_valid,
  output logic [DW-1:0]          rsp_rdata,
  output logic                   rsp_err,
  output logic [DW-1:0]          field,
  output logic [NUM_STROBES-1:0] strb,
  input  logic                   ack,
  input  logic [DW-1:0]          dout,
  output logic                   pace_clr,
  output logic                   pace_en,
  input  logic                   pace_tick,
  input  logic                   pace_last
);
  localparam int GW = $clog2(IDLE_CYCLES + 1);

  seq_state_t    state;
  step_t         step;
  logic          lvl;
  logic          is_wr;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [GW-1:0] gcnt;
  logic          err_q;
  logic [DW-1:0] rdata_q;
  logic          rst_special;

  assign cmd_ready   = (state == S_IDLE);
  assign rsp_valid   = (state == S_FIN);
  assign rsp_err     = err_q;
  assign rsp_rdata   = rdata_q;
  assign pace_clr    = (state == S_DRIVE);
  assign pace_en     = (state == S_WAIT);
  assign rst_special = is_wr && (addr_q == DW'(RST_ADDR)) && (data_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      step    <= ST_ADDR;
      lvl     <= 1'b0;
      is_wr   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      gcnt    <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      field   <= '0;
      strb    <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          is_wr  <= cmd_write;
          addr_q <= cmd_addr;
          data_q <= cmd_wdata;
          err_q  <= 1'b0;
          strb   <= '0;
          gcnt   <= '0;
          state  <= S_GAP;
        end
        S_GAP: if (gcnt == GW'(IDLE_CYCLES - 1)) begin
          step  <= ST_ADDR;
          lvl   <= 1'b1;
          state <= S_DRIVE;
        end else begin
          gcnt <= gcnt + 1'b1;
        end
        S_DRIVE: begin
          if (lvl && step != ST_RD) field <= (step == ST_ADDR) ? addr_q : data_q;
          strb[step] <= lvl;
          state <= (step == ST_WR && lvl && rst_special) ? S_FIN : S_WAIT;
        end
        S_WAIT: if (pace_tick && ack == lvl) begin
          if (step == ST_RD && lvl) rdata_q <= dout;
          if (lvl) begin
            lvl   <= 1'b0;
            state <= S_DRIVE;
          end else if (step == ST_WR || step == ST_RD) begin
            state <= S_FIN;
          end else begin
            step  <= (step == ST_ADDR) ? (is_wr ? ST_DATA : ST_RD) : ST_WR;
            lvl   <= 1'b1;
            state <= S_DRIVE;
          end
        end else if (pace_last) begin
          err_q <= 1'b1;
          strb  <= '0;
          state <= S_FIN;
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb)); // R10
  AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strb) && $past(|strb)) |-> $stable(field)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> $stable(rsp_err)); // R9
  AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_en && pace_last && ack != lvl) |=> (rsp_valid && rsp_err && strb == '0)); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid) |=> !cmd_ready); // R2

endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master
  import phyreg_hs_pkg::*;
#(
  parameter int          DW            = 16,
  parameter int          POLL_CYCLES   = 10000,
  parameter int          TIMEOUT_POLLS = 5000,
  parameter int          IDLE_CYCLES   = 10000,
  parameter logic [15:0] RST_ADDR      = 16'h7F3F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic [DW-1:0] phy_field,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_dout
);
  logic [NUM_STROBES-1:0] strb;
  logic pace_clr, pace_en, pace_tick, pace_last;

  phyreg_hs_pacer #(
    .POLL_CYCLES  (POLL_CYCLES),
    .TIMEOUT_POLLS(TIMEOUT_POLLS)
  ) u_pacer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pace_clr),
    .en   (pace_en),
    .tick (pace_tick),
    .last (pace_last)
  );

  phyreg_hs_seq #(
    .DW         (DW),
    .IDLE_CYCLES(IDLE_CYCLES),
    .RST_ADDR   (RST_ADDR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_write(cmd_write),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err),
    .field    (phy_field),
    .strb     (strb),
    .ack      (phy_ack),
    .dout     (phy_dout),
    .pace_clr (pace_clr),
    .pace_en  (pace_en),
    .pace_tick(pace_tick),
    .pace_last(pace_last)
  );

  assign phy_cap_addr = strb[ST_ADDR];
  assign phy_cap_data = strb[ST_DATA];
  assign phy_wr       = strb[ST_WR];
  assign phy_rd       = strb[ST_RD];

endmodule

// File: tb/phyreg_hs_master_tb.sv
module phyreg_hs_master_tb;
  localparam int          POLL = 2;
  localparam int          TO   = 8;
  localparam int          IDLE = 3;
  localparam logic [15:0] RSTA = 16'h7F3F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_rdata, phy_field, phy_dout;
  logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd;
  logic        phy_ack = 1'b0;

  always #4 clk = ~clk;

  phyreg_hs_master #(
    .DW(16), .POLL_CYCLES(POLL), .TIMEOUT_POLLS(TO), .IDLE_CYCLES(IDLE), .RST_ADDR(RSTA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .phy_field(phy_field), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack), .phy_dout(phy_dout)
  );

  // Behavioural PHY responder. mode 0: acks every strobe, 1: never acks,
  // 2: acks every strobe except the write strobe.
  int          mode = 0;
  logic [15:0] regs [16];
  logic [15:0] lat_addr = '0;
  logic        a1 = 1'b0, p_ca = 1'b0, p_wr = 1'b0;
  logic        tgt;

  initial for (int i = 0; i < 16; i++) regs[i] = '0;

  assign tgt = (mode == 1) ? 1'b0 :
               (mode == 2) ? (phy_cap_addr | phy_cap_data | phy_rd) :
                             (phy_cap_addr | phy_cap_data | phy_wr | phy_rd);
  assign phy_dout = regs[lat_addr[3:0]];

  always @(posedge clk) begin
    a1      <= tgt;
    phy_ack <= a1;
    p_ca    <= phy_cap_addr;
    p_wr    <= phy_wr;
    if (phy_cap_addr && !p_ca) lat_addr <= phy_field;
    if (phy_wr && !p_wr) regs[lat_addr[3:0]] <= phy_field;
  end

  int n_vec = 0, n_bad = 0, cyc = 0, acc_cyc = 0;
  int exp_idx[$];
  int exp_fld[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Cycle-by-cycle reference comparison on the PHY pins.
  logic [3:0]  sb_prev = '0;
  logic [15:0] fld_prev = '0;
  logic        v_prev = 1'b0;
  always @(negedge clk) begin
    logic [3:0] sb;
    cyc++;
    sb = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};
    if (rst_n) begin
      chk($onehot0(sb), "R10 onehot", int'(sb), 0);
      if (sb != 0 && sb_prev != 0)
        chk(phy_field == fld_prev, "R10 field held", int'(phy_field), int'(fld_prev));
      for (int i = 0; i < 4; i++) begin
        if (sb[i] && !sb_prev[i]) begin
          if (exp_idx.size() == 0) chk(1'b0, "R3 unexpected strobe", i, -1);
          else begin
            int ei, ef;
            ei = exp_idx.pop_front();
            ef = exp_fld.pop_front();
            chk(ei == i, "R3/R5/R6 strobe order", i, ei);
            if (ef >= 0) chk(int'(phy_field) == ef, "R3/R5 field value", int'(phy_field), ef);
            if (i == 0) chk(cyc - acc_cyc == IDLE + 2, "R11 idle gap", cyc - acc_cyc, IDLE + 2);
          end
        end
      end
      chk(!(rsp_valid && v_prev), "R9 one-cycle done", int'(rsp_valid), 0);
      if (rsp_valid) begin
        exp_idx.delete();
        exp_fld.delete();
      end
      if (cmd_valid && cmd_ready) acc_cyc = cyc;
    end
    sb_prev  = sb;
    fld_prev = phy_field;
    v_prev   = rsp_valid;
  end

  task automatic do_cmd(input bit w, input logic [15:0] a, input logic [15:0] d,
                        output logic [15:0] rd, output bit e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    exp_idx.push_back(0); exp_fld.push_back(int'(a));
    if (w) begin
      exp_idx.push_back(1); exp_fld.push_back(int'(d));
      exp_idx.push_back(2); exp_fld.push_back(int'(d));
    end else begin
      exp_idx.push_back(3); exp_fld.push_back(-1);
    end
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(rsp_err == 1'b0, "R9 err cleared on accept", int'(rsp_err), 0);
    chk(cmd_ready == 1'b0, "R2 busy after accept", int'(cmd_ready), 0);
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    e  = rsp_err;
  endtask

  initial begin
    logic [15:0] rd;
    bit e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    chk({phy_rd, phy_wr, phy_cap_data, phy_cap_addr} == 4'b0, "R1 strobes", 0, 0);
    chk(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 rsp", int'({rsp_valid, rsp_err}), 0);
    rst_n = 1'b1;

    // R5 writes, R6 reads, R4 handshake completes without error
    do_cmd(1'b1, 16'h0001, 16'h00A5, rd, e); chk(!e, "R5 write ok", int'(e), 0);
    do_cmd(1'b1, 16'h0005, 16'h5A5A, rd, e); chk(!e, "R5 write ok", int'(e), 0);
    do_cmd(1'b1, 16'h000E, 16'hFFFF, rd, e); chk(!e, "R4 write ok", int'(e), 0);
    do_cmd(1'b0, 16'h0005, 16'h0000, rd, e);
    chk(rd == 16'h5A5A && !e, "R6 read back", int'(rd), 16'h5A5A);
    do_cmd(1'b0, 16'h000E, 16'h0000, rd, e);
    chk(rd == 16'hFFFF && !e, "R6 read back", int'(rd), 16'hFFFF);
    do_cmd(1'b0, 16'h0001, 16'h0000, rd, e);
    chk(rd == 16'h00A5, "R6 read back", int'(rd), 16'h00A5);

    // R2 commands while busy are ignored
    @(negedge clk);
    exp_idx.push_back(0); exp_fld.push_back(2);
    exp_idx.push_back(1); exp_fld.push_back(16'h1234);
    exp_idx.push_back(2); exp_fld.push_back(16'h1234);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0002; cmd_wdata = 16'h1234;
    @(negedge clk);
    cmd_addr = 16'h0009; cmd_wdata = 16'hBEEF;
    for (int k = 0; k < 5; k++) begin
      chk(cmd_ready == 1'b0, "R2 ready low while busy", int'(cmd_ready), 0);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    do_cmd(1'b0, 16'h0009, 16'h0000, rd, e);
    chk(rd == 16'h0000, "R2 busy command ignored", int'(rd), 0);
    do_cmd(1'b0, 16'h0002, 16'h0000, rd, e);
    chk(rd == 16'h1234, "R2 first command done", int'(rd), 16'h1234);

    // R8 timeout, R9 error hold
    mode = 1;
    do_cmd(1'b1, 16'h0003, 16'h7777, rd, e);
    chk(e == 1'b1, "R8 write timeout", int'(e), 1);
    chk({phy_rd, phy_wr, phy_cap_data, phy_cap_addr} == 4'b0, "R8 strobes dropped", 0, 0);
    repeat (5) @(negedge clk);
    chk(rsp_err == 1'b1, "R9 err held", int'(rsp_err), 1);
    do_cmd(1'b0, 16'h0003, 16'h0000, rd, e);
    chk(e == 1'b1, "R8 read timeout", int'(e), 1);
    mode = 0;
    repeat (4) @(negedge clk);
    do_cmd(1'b0, 16'h0003, 16'h0000, rd, e);
    chk(!e && rd == 16'h0000, "R8 timed-out write not stored", int'(rd), 0);

    // R7 clock-reset register write
    mode = 2;
    do_cmd(1'b1, RSTA, 16'h0000, rd, e);
    chk(e == 1'b1, "R7 zero data uses handshake", int'(e), 1);
    do_cmd(1'b1, RSTA, 16'h0001, rd, e);
    chk(e == 1'b0, "R7 reset write no err", int'(e), 0);
    repeat (3) @(negedge clk);
    chk(phy_wr == 1'b1, "R7 write strobe left high", int'(phy_wr), 1);
    mode = 0;
    do_cmd(1'b0, 16'h0001, 16'h0000, rd, e);
    chk(rd == 16'h00A5 && !e, "R7 next access ok", int'(rd), 16'h00A5);
    chk(phy_wr == 1'b0, "R7 write strobe cleared", int'(phy_wr), 0);
    do_cmd(1'b0, RSTA, 16'h0000, rd, e);
    chk(rd == 16'h0001, "R7 reset data delivered", int'(rd), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

endmodule